// File: doc/BRIEF.md
# Display Test Pattern Generator

This block produces a synthetic raster of pixels so that a display path can be brought up before any real video source exists. A control word selects the pattern (one solid colour, stripes that alternate between two colours along each line, or stripes that alternate from line to line), the stripe width and the way a stop request is honoured. A size word gives the line length and the number of lines. Two colour words per colour carry the red, green and blue components. Pixels leave on a valid/ready stream that is marked at line start and frame start.

Setting the run bit starts a new frame at the top-left pixel. Clearing it asks the generator to stop, either after the last pixel of the current frame, after the last pixel of the current line, or at once. The running indication drops only when that stop actually takes effect. Any change of the running indication sets a sticky event flag. The flag is gated by a mask to form an interrupt and is removed by a clear pulse.

Top module: `testpat_gen`

## Requirements
- R1: After reset, pix_valid_o, running_o, int_flag_o and irq_o are all low.
- R2: Control word fields are run at bit 0, stop mode at bits 2:1, pattern at bits 4:3 and stripe width from bit 5 upward. With the generator idle, a high run bit sets running_o at the next clock edge. The first pixel offered is then line 0, column 0, with both pix_sol_o and pix_sof_o high.
- R3: Pixels come in raster order. Line length is in size-word bits 15:0 and line count starts at bit 16. pix_sol_o is high on column 0 and pix_sof_o on column 0 of line 0. After the last pixel of a frame the scan wraps to a new frame.
- R4: Pattern code 0 gives colour 1 on every pixel. Pixel data is {red, green, blue}. A colour's first word holds red in the low bits and green from bit 12; its second word holds blue in the low bits.
- R5: Pattern code 2 alternates colour every stripe-width pixels along a line. Each line starts with colour 1.
- R6: Pattern code 3 alternates colour every stripe-width lines. Each frame starts with colour 1.
- R7: A stripe width of 0 acts as a width of 1.
- R8: Stop code 0: once run is low, the generator stops right after the last pixel of the current frame is accepted.
- R9: Stop code 1: once run is low, the generator stops right after the last pixel of the current line is accepted.
- R10: Stop codes 2 and 3: no pixel is offered in a cycle where run is low, and running_o drops at the next edge.
- R11: While a pixel is offered and not accepted, the pixel and its markers stay unchanged in the following cycle, unless an immediate stop withdraws it.
- R12: Pattern, stripe width, image size and colours are captured when a run starts. Changing them during the run has no effect on the pixels.
- R13: int_flag_o goes high the cycle after running_o changes. A clear pulse with no such change lowers it at the next edge. irq_o is high only when both the flag and int_mask_i are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ctrl_i | input | 32 | Run, stop mode, pattern and stripe width |
| img_size_i | input | 32 | Line count (high half) and line length (low half) |
| col1_rg_i | input | 32 | Colour 1 red and green |
| col1_b_i | input | 32 | Colour 1 blue |
| col2_rg_i | input | 32 | Colour 2 red and green |
| col2_b_i | input | 32 | Colour 2 blue |
| int_mask_i | input | 1 | Interrupt enable for the event flag |
| int_clr_i | input | 1 | Clear pulse for the event flag |
| pix_ready_i | input | 1 | Downstream accepts the offered pixel |
| pix_valid_o | output | 1 | A pixel is offered |
| pix_data_o | output | 3*CW | Pixel {red, green, blue} |
| pix_sol_o | output | 1 | Pixel is the first of a line |
| pix_sof_o | output | 1 | Pixel is the first of a frame |
| running_o | output | 1 | Generator active |
| int_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with 12-bit colour components, 8-bit size fields and a 4-bit stripe-width field. With these narrow fields, frames of a few pixels are short enough for several frame wraps, horizontal stripe boundaries and every stop code to occur within a few dozen cycles. A cadence that stalls one cycle in three exercises the hold behaviour while stop requests are pending. A run held with ready low gives the status and interrupt checks a quiet window.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    STOP_AT_FRAME = 2'd0,
    STOP_AT_LINE  = 2'd1,
    STOP_AT_ONCE  = 2'd2,
    STOP_AT_ONCE2 = 2'd3
  } stop_mode_e;

  typedef enum logic [1:0] {
    PAT_SOLID   = 2'd0,
    PAT_SPARE   = 2'd1,
    PAT_COLSTRP = 2'd2,
    PAT_ROWSTRP = 2'd3
  } pat_mode_e;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

  localparam int CTRL_RUN_BIT    = 0;
  localparam int CTRL_STOP_LSB   = 1;
  localparam int CTRL_PAT_LSB    = 3;
  localparam int CTRL_STRIPE_LSB = 5;
  localparam int SIZE_LINES_LSB  = 16;
  localparam int COL_HI_LSB      = 12;

endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  stop_mode_e stop_mode_i,
  input  logic       fire_i,
  input  logic       last_x_i,
  input  logic       last_y_i,
  output logic       running_o,
  output logic       start_o,
  output logic       present_o
);

  gen_state_e st_q, st_d;
  logic [1:0] sm;
  logic       halt_now, line_end, frame_end, stop_hit;

  assign sm = stop_mode_i;

  always_comb begin
    start_o   = (st_q == GEN_IDLE) && run_i;
    halt_now  = (st_q == GEN_RUN) && !run_i && sm[1];
    line_end  = fire_i && last_x_i;
    frame_end = line_end && last_y_i;
    stop_hit  = (st_q == GEN_RUN) && !run_i &&
                (sm[1] || (sm[0] ? line_end : frame_end));
    st_d = st_q;
    case (st_q)
      GEN_IDLE: if (run_i)    st_d = GEN_RUN;
      GEN_RUN:  if (stop_hit) st_d = GEN_IDLE;
      default:                st_d = GEN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GEN_IDLE;
    else        st_q <= st_d;
  end

  assign running_o = (st_q == GEN_RUN);
  assign present_o = (st_q == GEN_RUN) && !halt_now;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o && run_i |=> running_o);

  // R8
  frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) && $past(sm) == 2'd0 |-> $past(fire_i && last_x_i && last_y_i));

  // R9
  line_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) && $past(sm) == 2'd1 |-> $past(fire_i && last_x_i));

  // R10
  now_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && !run_i && sm[1] |=> !running_o);

endmodule

// File: rtl/tpg_scan.sv
module tpg_scan #(
  parameter int XW = 16,
  parameter int YW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [XW-1:0] len_i,
  input  logic [YW-1:0] lines_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          last_x_o,
  output logic          last_y_o
);

  logic [XW-1:0] x_q, x_d, xmax;
  logic [YW-1:0] y_q, y_d, ymax;

  assign xmax     = (len_i == '0)   ? '0 : len_i - XW'(1);
  assign ymax     = (lines_i == '0) ? '0 : lines_i - YW'(1);
  assign last_x_o = (x_q == xmax);
  assign last_y_o = (y_q == ymax);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (clear_i) begin
      x_d = '0;
      y_d = '0;
    end else if (step_i) begin
      if (last_x_o) begin
        x_d = '0;
        y_d = last_y_o ? '0 : y_q + YW'(1);
      end else begin
        x_d = x_q + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  // R3
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> x_o <= xmax);

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && last_x_o && !clear_i |=> x_o == '0);

endmodule

// File: rtl/tpg_stripe.sv
module tpg_stripe #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [SW-1:0] size_i,
  output logic          phase_o
);

  logic [SW-1:0] cnt_q, cnt_d, lim;
  logic          ph_q, ph_d;

  assign lim = (size_i == '0) ? '0 : size_i - SW'(1);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (clear_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (step_i) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/tpg_status.sv
module tpg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic running_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);

  logic prev_q, flag_q, flag_d;

  always_comb begin
    flag_d = (running_i != prev_q) | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= running_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & mask_i;

  // R13
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_i != $past(running_i) |=> flag_o);

  // R13
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && $stable(running_i) |=> !flag_o);

endmodule

// File: rtl/testpat_gen.sv
module testpat_gen
  import tpg_pkg::*;
#(
  parameter int CW = 12,
  parameter int XW = 16,
  parameter int YW = 16,
  parameter int SW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     ctrl_i,
  input  logic [31:0]     img_size_i,
  input  logic [31:0]     col1_rg_i,
  input  logic [31:0]     col1_b_i,
  input  logic [31:0]     col2_rg_i,
  input  logic [31:0]     col2_b_i,
  input  logic            int_mask_i,
  input  logic            int_clr_i,
  input  logic            pix_ready_i,
  output logic            pix_valid_o,
  output logic [3*CW-1:0] pix_data_o,
  output logic            pix_sol_o,
  output logic            pix_sof_o,
  output logic            running_o,
  output logic            int_flag_o,
  output logic            irq_o
);

  localparam int PW = 3 * CW;

  logic       run_req;
  stop_mode_e stop_mode;
  pat_mode_e  pat_in;

  assign run_req   = ctrl_i[CTRL_RUN_BIT];
  assign stop_mode = stop_mode_e'(ctrl_i[CTRL_STOP_LSB +: 2]);
  assign pat_in    = pat_mode_e'(ctrl_i[CTRL_PAT_LSB +: 2]);

  logic [PW-1:0] col1_in, col2_in;
  assign col1_in = {col1_rg_i[0 +: CW], col1_rg_i[COL_HI_LSB +: CW], col1_b_i[0 +: CW]};
  assign col2_in = {col2_rg_i[0 +: CW], col2_rg_i[COL_HI_LSB +: CW], col2_b_i[0 +: CW]};

  // captured configuration
  pat_mode_e     pat_q, pat_d;
  logic [SW-1:0] strp_q, strp_d;
  logic [XW-1:0] len_q, len_d;
  logic [YW-1:0] lines_q, lines_d;
  logic [PW-1:0] c1_q, c1_d, c2_q, c2_d;

  logic start, present, fire, last_x, last_y, vph, hph, use_c2;
  logic [XW-1:0] xpos;
  logic [YW-1:0] ypos;

  always_comb begin
    pat_d   = pat_q;
    strp_d  = strp_q;
    len_d   = len_q;
    lines_d = lines_q;
    c1_d    = c1_q;
    c2_d    = c2_q;
    if (start) begin
      pat_d   = pat_in;
      strp_d  = ctrl_i[CTRL_STRIPE_LSB +: SW];
      len_d   = img_size_i[0 +: XW];
      lines_d = img_size_i[SIZE_LINES_LSB +: YW];
      c1_d    = col1_in;
      c2_d    = col2_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= PAT_SOLID;
      strp_q  <= '0;
      len_q   <= '0;
      lines_q <= '0;
      c1_q    <= '0;
      c2_q    <= '0;
    end else begin
      pat_q   <= pat_d;
      strp_q  <= strp_d;
      len_q   <= len_d;
      lines_q <= lines_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
    end
  end

  tpg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_req),
    .stop_mode_i (stop_mode),
    .fire_i      (fire),
    .last_x_i    (last_x),
    .last_y_i    (last_y),
    .running_o   (running_o),
    .start_o     (start),
    .present_o   (present)
  );

  assign pix_valid_o = present;
  assign fire        = present & pix_ready_i;

  tpg_scan #(.XW(XW), .YW(YW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start),
    .step_i   (fire),
    .len_i    (len_q),
    .lines_i  (lines_q),
    .x_o      (xpos),
    .y_o      (ypos),
    .last_x_o (last_x),
    .last_y_o (last_y)
  );

  tpg_stripe #(.SW(SW)) u_col_strp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start | (fire & last_x)),
    .step_i  (fire),
    .size_i  (strp_q),
    .phase_o (vph)
  );

  tpg_stripe #(.SW(SW)) u_row_strp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start | (fire & last_x & last_y)),
    .step_i  (fire & last_x),
    .size_i  (strp_q),
    .phase_o (hph)
  );

  assign use_c2 = ((pat_q == PAT_COLSTRP) & vph) | ((pat_q == PAT_ROWSTRP) & hph);

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign pix_data_o[ch*CW +: CW] = use_c2 ? c2_q[ch*CW +: CW] : c1_q[ch*CW +: CW];
  end

  assign pix_sol_o = (xpos == '0);
  assign pix_sof_o = (xpos == '0) && (ypos == '0);

  tpg_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .running_i (running_o),
    .mask_i    (int_mask_i),
    .clr_i     (int_clr_i),
    .flag_o    (int_flag_o),
    .irq_o     (irq_o)
  );

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o && !pix_ready_i |=>
      !pix_valid_o || ($stable(pix_data_o) && $stable(pix_sol_o) && $stable(pix_sof_o)));

endmodule

// File: tb/testpat_gen_tb_top.sv
`timescale 1ns/1ps
module testpat_gen_tb_top;

  localparam int CW = 12;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int SW = 4;
  localparam int PW = 3 * CW;

  typedef struct packed {
    logic [PW-1:0] d;
    logic          sol;
    logic          sof;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   ctrl, size_w, c1rg, c1b, c2rg, c2b;
  logic          mask, clr, ready;
  logic          pix_valid_o, pix_sol_o, pix_sof_o, running_o, int_flag_o, irq_o;
  logic [PW-1:0] pix_data_o;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   acc_cnt = 0;
  bit   bp_en = 1'b0;
  bit   hold0 = 1'b0;
  bit   done = 1'b0;
  int   cyc = 0;

  localparam logic [11:0] R1C = 12'h1A2, G1C = 12'h3B4, B1C = 12'h5C6;
  localparam logic [11:0] R2C = 12'hE01, G2C = 12'hD02, B2C = 12'hC03;
  localparam logic [PW-1:0] COL1 = {R1C, G1C, B1C};
  localparam logic [PW-1:0] COL2 = {R2C, G2C, B2C};

  always #2 clk = ~clk;

  testpat_gen #(.CW(CW), .XW(XW), .YW(YW), .SW(SW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl),
    .img_size_i  (size_w),
    .col1_rg_i   (c1rg),
    .col1_b_i    (c1b),
    .col2_rg_i   (c2rg),
    .col2_b_i    (c2b),
    .int_mask_i  (mask),
    .int_clr_i   (clr),
    .pix_ready_i (ready),
    .pix_valid_o (pix_valid_o),
    .pix_data_o  (pix_data_o),
    .pix_sol_o   (pix_sol_o),
    .pix_sof_o   (pix_sof_o),
    .running_o   (running_o),
    .int_flag_o  (int_flag_o),
    .irq_o       (irq_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] model_pix(int pat, int s, int x, int y);
    int ss;
    bit ph;
    ss = (s == 0) ? 1 : s;
    ph = 1'b0;
    if (pat == 2)      ph = ((x / ss) % 2) == 1;
    else if (pat == 3) ph = ((y / ss) % 2) == 1;
    return ph ? COL2 : COL1;
  endfunction

  task automatic push_run(int total, int pat, int s, int len, int lines);
    for (int i = 0; i < total; i++) begin
      exp_t e;
      int x, y;
      x = i % len;
      y = (i / len) % lines;
      e.d   = model_pix(pat, s, x, y);
      e.sol = (x == 0);
      e.sof = (x == 0) && (y == 0);
      exp_q.push_back(e);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit run, int stop, int pat, int s);
    return 32'(run) | (32'(stop) << 1) | (32'(pat) << 3) | (32'(s) << 5);
  endfunction

  // ready driver
  initial begin
    ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      ready = hold0 ? 1'b0 : (bp_en ? ((cyc % 3) != 1) : 1'b1);
    end
  end

  // monitor / scoreboard
  logic          prev_stall = 1'b0;
  logic [PW-1:0] prev_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && pix_valid_o)
        chk(pix_data_o == prev_data, "R11 stalled pixel held", pix_data_o, prev_data);
      prev_stall = pix_valid_o && !ready;
      prev_data  = pix_data_o;
      if (pix_valid_o && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8/R9/R10 unexpected extra pixel", pix_data_o, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          // R3 R4 R5 R6 R7 R12 pixel and marker compare
          chk({pix_data_o, pix_sol_o, pix_sof_o} == e, "R3-pixel/R4/R5/R6 scoreboard",
              {pix_data_o, pix_sol_o, pix_sof_o}, e);
        end
        acc_cnt++;
      end
    end
  end

  task automatic clear_flag();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
  endtask

  task automatic run_case(string tag, int pat, int stop, int s, int len, int lines,
                          int k, bit bp, bit mutate);
    int total, frame;
    frame = len * lines;
    if (stop == 0)      total = (k / frame + 1) * frame;
    else if (stop == 1) total = (k / len + 1) * len;
    else                total = k;
    @(posedge clk); #1;
    acc_cnt = 0;
    bp_en   = bp;
    push_run(total, pat, s, len, lines);
    size_w = (32'(lines) << 16) | 32'(len);
    c1rg = {8'h0, G1C, R1C}; c1b = {20'h0, B1C};
    c2rg = {8'h0, G2C, R2C}; c2b = {20'h0, B2C};
    ctrl = mk_ctrl(1'b1, stop, pat, s);
    if (mutate) begin
      @(posedge clk); @(posedge clk); #1;
      // R12: changes after start must not show
      c1rg = 32'h00ABC123; c1b = 32'h456; c2rg = 32'h0; c2b = 32'h0;
      size_w = (32'd1 << 16) | 32'd2;
      ctrl = mk_ctrl(1'b1, stop, 3, 3);
    end
    while (acc_cnt < k) @(posedge clk);
    #1 ctrl[0] = 1'b0;
    while (running_o) @(posedge clk);
    repeat (3) @(negedge clk);
    chk(acc_cnt == total, {tag, " accepted pixel count"}, acc_cnt, total);
    chk(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
    chk(!pix_valid_o && !running_o, {tag, " idle after stop"}, {pix_valid_o, running_o}, 0);
    bp_en = 1'b0;
    clear_flag();
    exp_q.delete();
  endtask

  // watchdog
  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ctrl = '0; size_w = '0; c1rg = '0; c1b = '0; c2rg = '0; c2b = '0;
    mask = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(!pix_valid_o && !running_o && !int_flag_o && !irq_o, "R1 reset state",
        {pix_valid_o, running_o, int_flag_o, irq_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_valid_o && !running_o && !int_flag_o && !irq_o, "R1 after release",
        {pix_valid_o, running_o, int_flag_o, irq_o}, 0);

    // status and start with ready held low
    hold0 = 1'b1;
    @(posedge clk); #1;
    mask = 1'b1;
    size_w = (32'd3 << 16) | 32'd4;
    c1rg = {8'h0, G1C, R1C}; c1b = {20'h0, B1C};
    c2rg = {8'h0, G2C, R2C}; c2b = {20'h0, B2C};
    ctrl = mk_ctrl(1'b1, 0, 0, 0);
    @(negedge clk);
    chk(!running_o, "R2 not yet running", running_o, 0);
    @(negedge clk);
    chk(running_o && pix_valid_o, "R2 running after one edge", {running_o, pix_valid_o}, 2'b11);
    chk(pix_sof_o && pix_sol_o && pix_data_o == COL1, "R2 first pixel top-left R4 colour",
        {pix_data_o, pix_sol_o, pix_sof_o}, {COL1, 2'b11});
    chk(!int_flag_o, "R13 flag one cycle later", int_flag_o, 0);
    @(negedge clk);
    chk(int_flag_o && irq_o, "R13 flag and irq set", {int_flag_o, irq_o}, 2'b11);
    @(posedge clk); #1 mask = 1'b0;
    @(negedge clk);
    chk(int_flag_o && !irq_o, "R13 masked irq", {int_flag_o, irq_o}, 2'b10);
    clear_flag();
    @(negedge clk);
    chk(!int_flag_o, "R13 flag cleared", int_flag_o, 0);
    // immediate stop while stalled: nothing accepted
    @(posedge clk); #1 ctrl = mk_ctrl(1'b0, 2, 0, 0);
    @(negedge clk);
    chk(!pix_valid_o, "R10 valid withdrawn at once", pix_valid_o, 0);
    @(negedge clk);
    chk(!running_o && acc_cnt == 0, "R10 stopped without transfer", {running_o, 8'(acc_cnt)}, 0);
    @(negedge clk);
    chk(int_flag_o, "R13 flag on stop", int_flag_o, 1);
    clear_flag();
    hold0 = 1'b0;

    run_case("R8 R4 solid frame stop",        0, 0, 0, 5, 3, 7,  1'b0, 1'b0);
    run_case("R9 R5 column stripes line stop", 2, 1, 2, 7, 3, 10, 1'b1, 1'b0);
    run_case("R8 R6 row stripes two frames",   3, 0, 2, 3, 5, 20, 1'b0, 1'b0);
    run_case("R10 R7 zero stripe now stop",    2, 2, 0, 4, 2, 5,  1'b0, 1'b0);
    run_case("R10 R6 code3 now stop stalls",   3, 3, 1, 4, 4, 9,  1'b1, 1'b0);
    run_case("R12 capture at start",           2, 1, 1, 4, 2, 2,  1'b0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule